// File: doc/BRIEF.md
# Guarded Integer-to-Float Conversion Unit

This block turns 32-bit two's-complement integers into IEEE-754 single-precision values. It has one or more conversion lanes, set by a parameter, that can each start a conversion in the same cycle. Each lane is a three-stage pipeline that accepts a new operand every cycle. Every result appears exactly three cycles after its operand is accepted. Each lane rounds according to a two-bit rounding mode taken from the processor status word.

The unit also holds the sticky exception-flag field of that status word. Only the inexact flag can be raised by a conversion. When several lanes finish inexact conversions in the same cycle, their updates are ORed together and with the stored value. An explicit software write is the only way to clear a flag, and it wins over any conversion update in the same cycle.

Each operation carries a guard bit. When the guard is 0, the lane presents no result, keeps its previous result value, and leaves the flags untouched.

Top module: `int2fp_unit`

## Requirements
- R1: An exactly representable source gives its exact single-precision encoding: 3 gives 0x40400000, -1 gives 0xBF800000, -3 gives 0xC0400000, 0x80000000 gives 0xCF000000, and 0 gives 0x00000000. None of these raises a flag.
- R2: Inexact values are rounded by `rnd_mode_i`: 00 is round-to-nearest-even, 01 is toward zero, 10 is toward +infinity and 11 is toward -infinity. For example, 0x7FFFFFFF under mode 00 gives 0x4F000000.
- R3: The inexact flag is `flags_o[0]`. It is raised exactly when rounding discards nonzero bits; 0x7FFFFFF1 gives 0x4F000000 and raises it. Conversions never change `flags_o[4:1]`.
- R4: A lane whose guard bit is 0 produces no valid result. Its `res_o` slice keeps its previous value, and its conversion does not touch the flags.
- R5: Flags are sticky. A bit that is set stays set until an explicit flag write.
- R6: When several lanes finish inexact conversions in the same cycle, the inexact flag becomes the OR of all their updates and its stored value.
- R7: When `flag_we_i` is high, the next `flags_o` equals `flag_wdata_i`. This write overrides any conversion update in the same cycle.
- R8: A result with a true guard appears on `res_valid_o` and `res_o` exactly 3 clock edges after its operand is sampled, and a lane accepts a new operand every cycle. The flag update for that result takes effect on the same edge.
- R9: After reset, `res_valid_o`, `res_o` and `flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | NUM_LANES | Issue strobe, one bit per lane |
| src_i | input | 32*NUM_LANES | Signed integer source, 32 bits per lane, lane 0 in the low bits |
| guard_i | input | NUM_LANES | Guard LSB, one bit per lane; 0 suppresses the operation |
| rnd_mode_i | input | 2 | Rounding mode from the status word |
| flag_we_i | input | 1 | Explicit flag-field write enable |
| flag_wdata_i | input | 5 | Value written to the flag field |
| res_valid_o | output | NUM_LANES | Result strobe, one bit per lane |
| res_o | output | 32*NUM_LANES | Single-precision results, lane 0 in the low bits |
| flags_o | output | 5 | Sticky exception flags; bit 0 is inexact |

## Verification
The assertions check the following on every cycle:
- Each result strobe follows its guarded issue by exactly three edges.
- A lane's result is held while its strobe is low.
- A flag bit can fall only after an explicit write, and that write wins.
- The upper flag bits never move without a write.
- The inexact flag can rise only on an edge that also delivers a result.

Only the bench scenarios can show that the encodings and rounding are numerically correct, and that same-cycle inexact updates from several lanes merge. The bench covers every rounding mode, power-of-two boundaries, the most negative value and zero, and compares each result against an arithmetic reference.

// File: rtl/int2fp_pkg.sv
package int2fp_pkg;
  localparam int DW       = 32;
  localparam int LZW      = $clog2(DW);
  localparam int FLAG_W   = 5;
  localparam int FLAG_INX = 0;
  localparam int MAN_W    = 23;
  localparam int EXP_W    = 8;
  localparam int BIAS_TOP = 127 + DW - 1;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_TO_POS    = 2'b10,
    RM_TO_NEG    = 2'b11
  } rmode_e;

  typedef struct packed {
    logic            go;
    logic            sign;
    logic [DW-1:0]   mag;
    rmode_e          mode;
  } stage1_t;

  typedef struct packed {
    logic            go;
    logic            sign;
    logic [LZW-1:0]  lz;
    logic [DW-1:0]   norm;
    rmode_e          mode;
  } stage2_t;
endpackage

// File: rtl/int2fp_lzc.sv
module int2fp_lzc #(
  parameter int W   = 32,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  // highest set bit wins; all-zero input yields 0
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/int2fp_lane.sv
module int2fp_lane
  import int2fp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] src_i,
  input  logic          guard_i,
  input  logic [1:0]    rnd_mode_i,
  output logic          res_valid_o,
  output logic [DW-1:0] res_o,
  output logic          upd_inx_o
);
  stage1_t s1_q;
  stage2_t s2_q;

  // stage 1: sign / magnitude split
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_q <= '0;
    else begin
      s1_q.go   <= valid_i & guard_i;
      s1_q.sign <= src_i[DW-1];
      s1_q.mag  <= src_i[DW-1] ? (~src_i + 1'b1) : src_i;
      s1_q.mode <= rmode_e'(rnd_mode_i);
    end
  end

  // stage 2: normalize
  logic [LZW-1:0] lz_d;
  int2fp_lzc #(.W(DW)) u_lzc (.vec_i(s1_q.mag), .cnt_o(lz_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s2_q <= '0;
    else begin
      s2_q.go   <= s1_q.go;
      s2_q.sign <= s1_q.sign;
      s2_q.lz   <= lz_d;
      s2_q.norm <= s1_q.mag << lz_d;
      s2_q.mode <= s1_q.mode;
    end
  end

  // stage 3: round and pack
  localparam int GB = DW - 1 - MAN_W - 1;  // guard bit position in norm
  logic          nonzero, lsb_b, grd_b, stk_b, inexact, up;
  logic [EXP_W-1:0] exp_f;
  logic [DW-1:0] packed_d;

  always_comb begin
    nonzero = s2_q.norm[DW-1];
    lsb_b   = s2_q.norm[GB+1];
    grd_b   = s2_q.norm[GB];
    stk_b   = |s2_q.norm[GB-1:0];
    inexact = grd_b | stk_b;
    unique case (s2_q.mode)
      RM_NEAR_EVEN: up = grd_b & (stk_b | lsb_b);
      RM_TO_ZERO:   up = 1'b0;
      RM_TO_POS:    up = ~s2_q.sign & inexact;
      default:      up = s2_q.sign & inexact;
    endcase
    exp_f    = EXP_W'(BIAS_TOP) - EXP_W'(s2_q.lz);
    // mantissa carry ripples into the exponent field
    packed_d = {s2_q.sign, exp_f, s2_q.norm[DW-2:GB+1]} + DW'(up);
    if (!nonzero) packed_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      res_valid_o <= s2_q.go;
      if (s2_q.go) res_o <= packed_d;
    end
  end

  assign upd_inx_o = s2_q.go & inexact;
endmodule

// File: rtl/int2fp_flags.sv
module int2fp_flags
  import int2fp_pkg::*;
#(
  parameter int NUM_LANES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flag_we_i,
  input  logic [FLAG_W-1:0]    flag_wdata_i,
  input  logic [NUM_LANES-1:0] upd_inx_i,
  output logic [FLAG_W-1:0]    flags_o
);
  logic [FLAG_W-1:0] set_d;
  always_comb begin
    set_d = '0;
    set_d[FLAG_INX] = |upd_inx_i;
  end

  // explicit write beats same-cycle conversion updates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flags_o <= '0;
    else if (flag_we_i) flags_o <= flag_wdata_i;
    else                flags_o <= flags_o | set_d;
  end
endmodule

// File: rtl/int2fp_unit.sv
module int2fp_unit
  import int2fp_pkg::*;
#(
  parameter int NUM_LANES = 2,
  localparam int BUS_W    = NUM_LANES * DW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] valid_i,
  input  logic [BUS_W-1:0]     src_i,
  input  logic [NUM_LANES-1:0] guard_i,
  input  logic [1:0]           rnd_mode_i,
  input  logic                 flag_we_i,
  input  logic [FLAG_W-1:0]    flag_wdata_i,
  output logic [NUM_LANES-1:0] res_valid_o,
  output logic [BUS_W-1:0]     res_o,
  output logic [FLAG_W-1:0]    flags_o
);
  logic [NUM_LANES-1:0] upd_inx;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    int2fp_lane u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .valid_i     (valid_i[l]),
      .src_i       (src_i[l*DW +: DW]),
      .guard_i     (guard_i[l]),
      .rnd_mode_i  (rnd_mode_i),
      .res_valid_o (res_valid_o[l]),
      .res_o       (res_o[l*DW +: DW]),
      .upd_inx_o   (upd_inx[l])
    );
  end

  int2fp_flags #(.NUM_LANES(NUM_LANES)) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flag_we_i    (flag_we_i),
    .flag_wdata_i (flag_wdata_i),
    .upd_inx_i    (upd_inx),
    .flags_o      (flags_o)
  );
endmodule

// File: rtl/int2fp_unit_chk.sv
module int2fp_unit_chk
  import int2fp_pkg::*;
#(
  parameter int NUM_LANES = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_LANES-1:0]    valid_i,
  input logic [NUM_LANES-1:0]    guard_i,
  input logic                    flag_we_i,
  input logic [FLAG_W-1:0]       flag_wdata_i,
  input logic [NUM_LANES-1:0]    res_valid_o,
  input logic [NUM_LANES*DW-1:0] res_o,
  input logic [FLAG_W-1:0]       flags_o
);
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic [NUM_LANES-1:0] go_in;
  assign go_in = valid_i & guard_i;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_chk
    AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst == 2'd3) |-> (res_valid_o[l] == $past(go_in[l], 3))); // R8
    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst != 2'd0 && !res_valid_o[l]) |-> $stable(res_o[l*DW +: DW])); // R4
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd0 && !$past(flag_we_i)) |-> ((flags_o & $past(flags_o)) == $past(flags_o))); // R5
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd0 && $past(flag_we_i)) |-> (flags_o == $past(flag_wdata_i))); // R7
  AST_UPPER_FLAGS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd0 && !$past(flag_we_i)) |-> (flags_o[FLAG_W-1:1] == $past(flags_o[FLAG_W-1:1]))); // R3
  AST_INX_WITH_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 2'd0 && !$past(flag_we_i) && flags_o[FLAG_INX] && !$past(flags_o[FLAG_INX]))
      |-> (|res_valid_o)); // R8
endmodule

bind int2fp_unit int2fp_unit_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .guard_i      (guard_i),
  .flag_we_i    (flag_we_i),
  .flag_wdata_i (flag_wdata_i),
  .res_valid_o  (res_valid_o),
  .res_o        (res_o),
  .flags_o      (flags_o)
);

// File: tb/int2fp_unit_bench.sv
`timescale 1ns/1ps
module int2fp_unit_bench;
  localparam int L    = 2;
  localparam int NCYC = 40000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [L-1:0]  valid = '0;
  logic [L*32-1:0] src = '0;
  logic [L-1:0]  guard = '0;
  logic [1:0]    mode = '0;
  logic          fwe = 1'b0;
  logic [4:0]    fwd = '0;
  logic [L-1:0]  res_valid;
  logic [L*32-1:0] res;
  logic [4:0]    flags;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  int2fp_unit #(.NUM_LANES(L)) u_int2fp_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .src_i(src), .guard_i(guard),
    .rnd_mode_i(mode), .flag_we_i(fwe), .flag_wdata_i(fwd),
    .res_valid_o(res_valid), .res_o(res), .flags_o(flags)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // arithmetic reference: {inexact, float bits}
  function automatic logic [32:0] ref_cvt(input logic [31:0] x, input logic [1:0] m);
    logic s, up, inx;
    logic [63:0] a, q, r, half;
    int e, sh;
    s = x[31];
    a = s ? (64'd0 - {{32{1'b1}}, x}) : {32'd0, x};
    if (a == 0) return 33'd0;
    e = 0;
    while ((a >> (e + 1)) != 0) e++;
    if (e <= 23) begin
      q = a << (23 - e); inx = 1'b0; up = 1'b0;
    end else begin
      sh = e - 23;
      q = a >> sh;
      r = a - (q << sh);
      half = 64'd1 << (sh - 1);
      inx = (r != 0);
      case (m)
        2'd0: up = (r > half) || ((r == half) && q[0]);
        2'd1: up = 1'b0;
        2'd2: up = !s && inx;
        default: up = s && inx;
      endcase
    end
    q = q + {63'd0, up};
    if (q == (64'd1 << 24)) begin q = 64'd1 << 23; e++; end
    return {inx, s, 8'(e + 127), q[22:0]};
  endfunction

  function automatic logic [31:0] directed(input int i);
    case (i % 8)
      0: return 32'd3;
      1: return 32'hffffffff;
      2: return 32'hfffffffd;
      3: return 32'h7fffffff;
      4: return 32'h7ffffff1;
      5: return 32'h80000000;
      6: return 32'd0;
      default: return 32'h01000001;
    endcase
  endfunction

  // history rings, index n%4
  logic [L-1:0]    h_go [4];
  logic [L*32-1:0] h_src [4];
  logic [1:0]      h_mode [4];
  logic            h_we [4];
  logic [4:0]      h_wd [4];
  logic [31:0]     exp_res [L];
  logic [4:0]      exp_flags;

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      h_go[i] = '0; h_src[i] = '0; h_mode[i] = '0; h_we[i] = 1'b0; h_wd[i] = '0;
    end
    for (int l = 0; l < L; l++) exp_res[l] = '0;
    exp_flags = '0;
    repeat (3) @(negedge clk);
    chk(res_valid == '0, "R9 valid in reset", 32'(res_valid), 32'd0);
    chk(flags == '0, "R9 flags in reset", 32'(flags), 32'd0);
    rst_n = 1'b1;
    chk(res == '0, "R9 result after reset", res[31:0], 32'd0);

    for (int n = 0; n < NCYC; n++) begin
      int io, iw;
      logic any_inx;
      int n_inx;
      @(negedge clk);
      io = (n + 1) % 4;
      iw = (n + 3) % 4;
      n_inx = 0;
      for (int l = 0; l < L; l++) begin
        logic [32:0] rv;
        rv = ref_cvt(h_src[io][l*32 +: 32], h_mode[io]);
        if (h_go[io][l]) begin
          chk(res_valid[l] == 1'b1, "R8 valid after 3 edges", 32'(res_valid[l]), 32'd1);
          chk(res[l*32 +: 32] == rv[31:0], rv[32] ? "R2 rounded result" : "R1 exact result",
              res[l*32 +: 32], rv[31:0]);
          exp_res[l] = rv[31:0];
          if (rv[32]) n_inx++;
        end else begin
          chk(res_valid[l] == 1'b0, "R8 no valid", 32'(res_valid[l]), 32'd0);
          chk(res[l*32 +: 32] == exp_res[l], "R4 result held", res[l*32 +: 32], exp_res[l]);
        end
      end
      any_inx = (n_inx != 0);
      if (h_we[iw]) exp_flags = h_wd[iw];
      else exp_flags[0] = exp_flags[0] | any_inx;
      chk(flags == exp_flags,
          h_we[iw] ? "R7 write priority" : (n_inx > 1) ? "R6 merged flags" :
          any_inx ? "R3 inexact flag" : "R5 sticky flags",
          32'(flags), 32'(exp_flags));

      // drive S_n
      if (n < 24) begin
        mode = 2'd0;
        valid = '1;
        guard = (n == 10) ? 2'b10 : 2'b11;
        src = {directed(n + 3), directed(n)};
        fwe = (n == 12);
        fwd = 5'd0;
      end else begin
        logic [31:0] a, b;
        int k;
        k = n % 31;
        a = 32'(n * 37) ^ 32'(n << 13) ^ 32'(n * n);
        b = (32'd1 << k) + 32'((n / 31) % 5) - 32'd2;
        if (n[5]) b = -b;
        if ((n % 97) < 8) a = 32'h7fffffff - 32'(n % 8);
        mode  = 2'((n >> 2) & 3);
        valid = {((n % 13) != 5), ((n % 17) != 9)};
        guard = {((n % 11) != 3), ((n % 7) != 0)};
        src   = {b, a};
        fwe   = ((n % 53) == 0);
        fwd   = 5'((n / 53) % 32);
      end
      h_go[n % 4]   = valid & guard;
      h_src[n % 4]  = src;
      h_mode[n % 4] = mode;
      h_we[n % 4]   = fwe;
      h_wd[n % 4]   = fwd;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule